// File: doc/BRIEF.md
# Debug Execution Control Port

This block is a host-facing control port for a small processing engine. The host talks to four word-wide registers: a data register, an address register, a combined command/status register and an instruction watch counter. Writing the command register starts, halts or single-steps the engine, clears status flags, or performs an indirect access. An indirect access reaches the instruction memory, the data memory or a bank of execution-context registers, using the address register as the index and the data register as the source or destination.

For a write, the host loads the data register, then the address register, then issues the command. For a read, the host loads the address register and issues the command. The result lands in the data register a fixed number of cycles later. The host reads the data register three times and keeps the third value. The same register that accepts commands returns the engine's run state and two sticky flags when it is read.

The engine is modelled only as far as the port can see it. While it runs, it retires one instruction per cycle. Each retired instruction advances the watch counter and the next-PC field of context register 0.

Top module: `exec_debug_port`

## Requirements
- R1: After reset the engine is halted, the status reads 0x4080_0000 (bit 30 halted, bit 23 pipeline clean) and the watch counter reads 0.
- R2: host_sel selects 0 data, 1 address, 2 command/status, 3 watch counter. host_rdata shows the selected register one cycle after host_rd.
- R3: Command codes 0x11, 0x13 and 0x15 store the data register into instruction memory, data memory or context register respectively. The index is the low bits of the address register, so higher bits alias.
- R4: Command codes 0x10, 0x12 and 0x14 copy the addressed word into the data register. By the third data-register read after the command, the host sees the value.
- R5: Code 0x02 sets the running state (status bit 31 set, bit 30 clear). Code 0x03 clears it.
- R6: Code 0x01 while halted retires exactly one instruction. While running it adds nothing beyond the normal one per cycle.
- R7: The watch counter rises by one per retired instruction, which is one per cycle while running. A host write to it loads the written value.
- R8: Each retired instruction adds one to bits 28:16 of context register 0 and keeps its other bits; the field wraps from 0x1FFF to 0. Context register 0x11 holds the instruction word written to it.
- R9: Code 0x04 sets status bit 23 and code 0x0C sets status bit 29. Each flag is cleared by the next retired instruction.
- R10: The command code is host_wdata[7:0]. Any other code leaves the status and the watch counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_sel | input | 2 | Register select |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |

## Verification
The assertions assume one host access per cycle: host_wr and host_rd are never high together, and host_sel and host_wdata are stable while a strobe is high. The assertions also assume that a command is only judged by its low byte. The bench drives every access from a single task, one per clock, changing inputs only on the falling edge. It issues clear-flag and memory commands only while the engine is halted, so that flag and counter values depend on no same-cycle race between a command and a retiring instruction.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;
  localparam logic [7:0] OP_STEP     = 8'h01;
  localparam logic [7:0] OP_START    = 8'h02;
  localparam logic [7:0] OP_HALT     = 8'h03;
  localparam logic [7:0] OP_FLUSH    = 8'h04;
  localparam logic [7:0] OP_PROF_CLR = 8'h0C;
  localparam logic [7:0] OP_IRD      = 8'h10;
  localparam logic [7:0] OP_IWR      = 8'h11;
  localparam logic [7:0] OP_DRD      = 8'h12;
  localparam logic [7:0] OP_DWR      = 8'h13;
  localparam logic [7:0] OP_CRD      = 8'h14;
  localparam logic [7:0] OP_CWR      = 8'h15;

  localparam logic [1:0] SEL_DATA  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_WATCH = 2'd3;

  typedef enum logic [1:0] {SRC_NONE, SRC_IMEM, SRC_DMEM, SRC_CTX} src_e;

  function automatic logic op_known(input logic [7:0] c);
    case (c)
      OP_STEP, OP_START, OP_HALT, OP_FLUSH, OP_PROF_CLR,
      OP_IRD, OP_IWR, OP_DRD, OP_DWR, OP_CRD, OP_CWR: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dbgport_ram.sv
module dbgport_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dbgport_ctx_bank.sv
module dbgport_ctx_bank #(
  parameter int IDXW   = 5,
  parameter int DW     = 32,
  parameter int PC_LSB = 16,
  parameter int PC_W   = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  input  logic            adv,
  output logic [DW-1:0]   rdata
);
  localparam int NREG = 1 << IDXW;
  logic [NREG-1:0][DW-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] r;
    assign flat[i] = r;
    if (i == 0) begin : g_pc
      // level-0 background context: next-PC field follows retired instructions
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else if (we && idx == IDXW'(i)) r <= wdata;
        else if (adv) r[PC_LSB +: PC_W] <= r[PC_LSB +: PC_W] + 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else if (we && idx == IDXW'(i)) r <= wdata;
      end
    end
  end

  always_ff @(posedge clk) rdata <= flat[idx];
endmodule

// File: rtl/dbgport_engine.sv
module dbgport_engine #(
  parameter int WCW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_code,
  input  logic           watch_we,
  input  logic [WCW-1:0] watch_wdata,
  output logic           running,
  output logic           exec_pulse,
  output logic [WCW-1:0] watch_cnt,
  output logic [31:0]    status
);
  import dbgport_pkg::*;

  logic flush_flag, prof_flag;
  logic do_step, do_start, do_halt, do_flush, do_prof;

  always_comb begin
    do_step  = cmd_valid && cmd_code == OP_STEP;
    do_start = cmd_valid && cmd_code == OP_START;
    do_halt  = cmd_valid && cmd_code == OP_HALT;
    do_flush = cmd_valid && cmd_code == OP_FLUSH;
    do_prof  = cmd_valid && cmd_code == OP_PROF_CLR;
    exec_pulse = running || do_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      flush_flag <= 1'b1;
      prof_flag  <= 1'b0;
      watch_cnt  <= '0;
    end else begin
      if (do_start) running <= 1'b1;
      else if (do_halt) running <= 1'b0;

      if (watch_we) watch_cnt <= watch_wdata;
      else if (exec_pulse) watch_cnt <= watch_cnt + 1'b1;

      if (do_flush) flush_flag <= 1'b1;
      else if (exec_pulse) flush_flag <= 1'b0;

      if (do_prof) prof_flag <= 1'b1;
      else if (exec_pulse) prof_flag <= 1'b0;
    end
  end

  assign status = {running, ~running, prof_flag, 5'b0, flush_flag, 23'b0};
endmodule

// File: rtl/exec_debug_port.sv
module exec_debug_port #(
  parameter int IAW = 8,
  parameter int DAW = 8,
  parameter int CIW = 5,
  parameter int DW  = 32,
  parameter int WCW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  import dbgport_pkg::*;

  localparam int AMW = (IAW > DAW) ? ((IAW > CIW) ? IAW : CIW)
                                   : ((DAW > CIW) ? DAW : CIW);

  logic [DW-1:0]  data_q;
  logic [AMW-1:0] addr_q;
  src_e           src_q;
  logic           wr_ctrl;
  logic [7:0]     code;
  logic           imem_we, dmem_we, ctx_we;
  src_e           src_d;
  logic [DW-1:0]  imem_q, dmem_q, ctx_q;
  logic           running, exec_pulse;
  logic [WCW-1:0] watch_cnt;
  logic [31:0]    status;

  always_comb begin
    wr_ctrl = host_wr && host_sel == SEL_CTRL;
    code    = host_wdata[7:0];
    imem_we = wr_ctrl && code == OP_IWR;
    dmem_we = wr_ctrl && code == OP_DWR;
    ctx_we  = wr_ctrl && code == OP_CWR;
    src_d   = SRC_NONE;
    if (wr_ctrl) begin
      case (code)
        OP_IRD:  src_d = SRC_IMEM;
        OP_DRD:  src_d = SRC_DMEM;
        OP_CRD:  src_d = SRC_CTX;
        default: src_d = SRC_NONE;
      endcase
    end
  end

  dbgport_ram #(.AW(IAW), .DW(DW)) u_imem (
    .clk(clk), .we(imem_we), .addr(addr_q[IAW-1:0]), .wdata(data_q), .rdata(imem_q));

  dbgport_ram #(.AW(DAW), .DW(DW)) u_dmem (
    .clk(clk), .we(dmem_we), .addr(addr_q[DAW-1:0]), .wdata(data_q), .rdata(dmem_q));

  dbgport_ctx_bank #(.IDXW(CIW), .DW(DW)) u_ctx (
    .clk(clk), .rst(rst), .we(ctx_we), .idx(addr_q[CIW-1:0]), .wdata(data_q),
    .adv(exec_pulse), .rdata(ctx_q));

  dbgport_engine #(.WCW(WCW)) u_eng (
    .clk(clk), .rst(rst), .cmd_valid(wr_ctrl), .cmd_code(code),
    .watch_we(host_wr && host_sel == SEL_WATCH), .watch_wdata(host_wdata[WCW-1:0]),
    .running(running), .exec_pulse(exec_pulse), .watch_cnt(watch_cnt), .status(status));

  // host registers; a direct host write to data wins over a returning read
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      addr_q <= '0;
      src_q  <= SRC_NONE;
    end else begin
      src_q <= src_d;
      if (host_wr && host_sel == SEL_ADDR) addr_q <= host_wdata[AMW-1:0];
      if (host_wr && host_sel == SEL_DATA) data_q <= host_wdata;
      else begin
        case (src_q)
          SRC_IMEM: data_q <= imem_q;
          SRC_DMEM: data_q <= dmem_q;
          SRC_CTX:  data_q <= ctx_q;
          default:  data_q <= data_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) begin
      case (host_sel)
        SEL_DATA:  host_rdata <= data_q;
        SEL_ADDR:  host_rdata <= DW'(addr_q);
        SEL_CTRL:  host_rdata <= DW'(status);
        default:   host_rdata <= DW'(watch_cnt);
      endcase
    end
  end
endmodule

// File: rtl/exec_debug_port_chk.sv
module exec_debug_port_chk #(
  parameter int DW  = 32,
  parameter int WCW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic          host_rd,
  input logic [1:0]    host_sel,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] host_rdata,
  input logic          running,
  input logic [WCW-1:0] watch_cnt
);
  import dbgport_pkg::*;

  logic cmd_wr, wwr;
  assign cmd_wr = host_wr && host_sel == SEL_CTRL;
  assign wwr    = host_wr && host_sel == SEL_WATCH;

  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && host_wdata[7:0] == OP_START) |=> running);

  assert_halt_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && host_wdata[7:0] == OP_HALT) |=> !running);

  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && host_wdata[7:0] == OP_STEP && !running) |=> watch_cnt == $past(watch_cnt) + 1'b1);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!running && !wwr && !(cmd_wr && host_wdata[7:0] == OP_STEP)) |=> $stable(watch_cnt));

  assert_unknown_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !op_known(host_wdata[7:0])) |=> running == $past(running));

  assert_watch_read_R2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_sel == SEL_WATCH) |=> host_rdata == DW'($past(watch_cnt)));
endmodule

bind exec_debug_port exec_debug_port_chk u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .running(running),
  .watch_cnt(watch_cnt));

// File: tb/sim_exec_debug_port.sv
`timescale 1ns/1ps
module sim_exec_debug_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  logic [31:0] q_exp[$];
  bit          q_dc[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  exec_debug_port u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata));

  // monitor: compare each returned read against the scoreboard
  always @(posedge clk) rd_seen <= host_rd;
  always @(negedge clk) begin
    if (rd_seen && q_exp.size() > 0) begin
      logic [31:0] e;
      bit dc;
      string t;
      e = q_exp.pop_front();
      dc = q_dc.pop_front();
      t = q_tag.pop_front();
      if (!dc) begin
        vectors++;
        if (host_rdata !== e) begin
          miscompares++;
          $display("FAIL %s: got %08h expected %08h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [1:0] s, input logic [31:0] d);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, input logic [31:0] e, input bit dc, input string t);
    host_rd = 1'b1; host_sel = s;
    q_exp.push_back(e); q_dc.push_back(dc); q_tag.push_back(t);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic mem_wr(input logic [7:0] op, input logic [31:0] a, input logic [31:0] v);
    bus_wr(2'd0, v);
    bus_wr(2'd1, a);
    bus_wr(2'd2, {24'd0, op});
  endtask

  task automatic mem_rd(input logic [7:0] op, input logic [31:0] a, input logic [31:0] e, input string t);
    bus_wr(2'd1, a);
    bus_wr(2'd2, {24'd0, op});
    bus_rd(2'd0, 32'h0, 1'b1, t);
    bus_rd(2'd0, 32'h0, 1'b1, t);
    bus_rd(2'd0, e, 1'b0, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    bus_rd(2'd2, 32'h4080_0000, 1'b0, "R1 status");
    bus_rd(2'd3, 32'h0, 1'b0, "R1 watch");
    // R3 indirect writes into each store
    mem_wr(8'h11, 32'h03, 32'h1111_AAAA);
    mem_wr(8'h13, 32'h03, 32'h2222_BBBB);
    mem_wr(8'h15, 32'h11, 32'h0BAD_F00D);
    mem_wr(8'h15, 32'h00, 32'h8000_0500);
    // R4 readback, third data read
    mem_rd(8'h10, 32'h03, 32'h1111_AAAA, "R4 imem");
    mem_rd(8'h12, 32'h03, 32'h2222_BBBB, "R4 dmem");
    mem_rd(8'h14, 32'h11, 32'h0BAD_F00D, "R8 instr reg");
    mem_rd(8'h14, 32'h05, 32'h0, "R4 ctx untouched");
    mem_rd(8'h10, 32'h103, 32'h1111_AAAA, "R3 alias");
    // R6 single step while halted
    bus_wr(2'd2, 32'h01);
    bus_rd(2'd3, 32'd1, 1'b0, "R6 step watch");
    bus_rd(2'd2, 32'h4000_0000, 1'b0, "R9 flags cleared by step");
    mem_rd(8'h14, 32'h00, 32'h8001_0500, "R8 next pc step");
    // R9 flag commands
    bus_wr(2'd2, 32'h04);
    bus_rd(2'd2, 32'h4080_0000, 1'b0, "R9 flush flag");
    bus_wr(2'd2, 32'h0C);
    bus_rd(2'd2, 32'h6080_0000, 1'b0, "R9 profile flag");
    // R10 unknown codes
    bus_wr(2'd2, 32'h07);
    bus_wr(2'd2, 32'hFF);
    bus_rd(2'd2, 32'h6080_0000, 1'b0, "R10 status");
    bus_rd(2'd3, 32'd1, 1'b0, "R10 watch");
    // R5 run: start, idle, read, step (ignored), halt -> 4 retired
    bus_wr(2'd2, 32'h02);
    @(negedge clk);
    bus_rd(2'd2, 32'h8000_0000, 1'b0, "R5 running");
    bus_wr(2'd2, 32'h01);
    bus_wr(2'd2, 32'h03);
    bus_rd(2'd3, 32'd5, 1'b0, "R7 run count / R6 step ignored");
    bus_rd(2'd2, 32'h4000_0000, 1'b0, "R5 halted");
    mem_rd(8'h14, 32'h00, 32'h8005_0500, "R8 next pc run");
    // R7 watch load
    bus_wr(2'd3, 32'h0000_FFF0);
    bus_rd(2'd3, 32'h0000_FFF0, 1'b0, "R7 load");
    bus_wr(2'd2, 32'h01);
    bus_rd(2'd3, 32'h0000_FFF1, 1'b0, "R7 load then step");
    // R8 next-pc wrap
    mem_wr(8'h15, 32'h00, 32'h9FFF_0700);
    bus_wr(2'd2, 32'h01);
    mem_rd(8'h14, 32'h00, 32'h8000_0700, "R8 wrap");
    bus_rd(2'd3, 32'h0000_FFF2, 1'b0, "R7 after wrap step");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule